// File: doc/BRIEF.md
# Microtile Row Scatter-Gather Engine

This block copies one 64-byte microtile between a tiled image and a linear raster buffer. In the tiled image the 64 bytes sit at consecutive addresses. In the raster buffer the same bytes are split into rows, and consecutive rows are one programmable stride apart. The pixel size sets the row shape. A 1-byte pixel gives 8 rows of 8 bytes. A 2-, 4- or 8-byte pixel gives 4 rows of 16 bytes.

A controller supplies the copy direction, the pixel size, the two base addresses and the raster stride, then pulses start. The engine moves the data in eight 8-byte beats. For each beat it issues one read request, waits for the read data, and issues one write request. All three exchanges use simple valid/ready channels with byte addresses. The beat order is fixed, so one address walk serves both directions: only the roles of the read side and the write side are swapped.

Top module: `utile_mover`

## Requirements
- R1: After reset, busy_o, done_o, err_o, rd_valid_o and wr_valid_o are all low.
- R2: With pix_bytes_i = 1, beat k (k = 0..7) covers linear bytes lin_base_i + k*lin_stride_i through +7, so row k is 8 bytes long.
- R3: With pix_bytes_i of 2, 4 or 8, beat k covers linear bytes lin_base_i + (k>>1)*lin_stride_i + 8*(k&1) through +7. Row k>>1 is 16 bytes long: the low half is moved first, then the high half.
- R4: Beat k covers tiled bytes tile_base_i + 8*k through +7, so the whole microtile spans 64 consecutive tiled bytes.
- R5: With to_linear_i = 1, beats read the tiled side and write the linear side. With to_linear_i = 0 the same beat mapping is used with reads on the linear side and writes on the tiled side. No byte outside the 64 destination bytes is written.
- R6: A start while idle with a pixel size other than 1, 2, 4 or 8 makes err_o high for exactly the next cycle. No request is issued and busy_o stays low.
- R7: busy_o rises in the cycle after an accepted start. done_o is high for exactly one cycle, in the cycle after the eighth write is accepted, and busy_o is low in that same cycle.
- R8: start_i is ignored while busy_o is high. The transfer in progress keeps its captured configuration, and no second transfer follows.
- R9: A read request holds rd_valid_o and rd_addr_o unchanged until rd_ready_i is seen. A write request holds wr_valid_o, wr_addr_o and wr_data_o unchanged until wr_ready_i is seen.
- R10: Each write carries the 8 data bytes returned for the read of the same beat, little-endian: bits [8n+7:8n] belong to address +n. At most one of rd_valid_o and wr_valid_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| to_linear_i | input | 1 | 1: tiled to linear, 0: linear to tiled |
| pix_bytes_i | input | 4 | Bytes per pixel (1, 2, 4 or 8) |
| tile_base_i | input | AW | Byte address of the microtile in the tiled image |
| lin_base_i | input | AW | Byte address of the first raster row |
| lin_stride_i | input | AW | Byte distance between raster rows |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read request byte address |
| rd_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data, little-endian |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | AW | Write request byte address |
| wr_data_o | output | 64 | Write data, little-endian |
| wr_ready_i | input | 1 | Write request accepted |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | One-cycle pulse for a rejected start |

## Verification
The bench copies a microtile for every legal pixel size, in both directions, at four strides. The strides are the packed row length, the row length plus 3, 37 and 100. The packed stride exposes errors in the row order. The odd and non-power-of-two strides expose address arithmetic that uses shifts or merges bits instead of adding. Before each run a distinct byte pattern is written over the whole memory image, and the image after the transfer is compared with a full expected image. This separates a misplaced half row, a swapped direction or a stray write from a correct copy. The memory ports stall at random, and further runs cover rejected pixel sizes and a start issued mid-transfer.

// File: rtl/utile_pkg.sv
package utile_pkg;

    localparam int TILE_BYTES = 64;
    localparam int BEAT_BYTES = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD,
        S_RSP,
        S_WR
    } mover_state_t;

    typedef struct packed {
        logic load;  // 1: tiled side is read, linear side written
        logic wide;  // 1: raster rows of two beats
    } mover_mode_t;

    function automatic logic pix_legal(input logic [3:0] pb);
        return (pb == 4'd1) || (pb == 4'd2) || (pb == 4'd4) || (pb == 4'd8);
    endfunction

    function automatic logic pix_wide(input logic [3:0] pb);
        return pb != 4'd1;
    endfunction

endpackage

// File: rtl/utile_addr_gen.sv
module utile_addr_gen
    import utile_pkg::*;
#(
    parameter int AW = 32,
    parameter int BEAT_B = BEAT_BYTES,
    parameter int BW = 3
) (
    input  mover_mode_t   mode_i,
    input  logic [BW-1:0] beat_i,
    input  logic [AW-1:0] tile_base_i,
    input  logic [AW-1:0] lin_base_i,
    input  logic [AW-1:0] stride_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o
);
    localparam int SH = $clog2(BEAT_B);

    logic [BW-1:0] row;
    logic          upper_half;
    logic [AW-1:0] tiled_addr;
    logic [AW-1:0] lin_addr;

    always_comb begin
        row        = mode_i.wide ? (beat_i >> 1) : beat_i;
        upper_half = mode_i.wide & beat_i[0];
        tiled_addr = tile_base_i + (AW'(beat_i) << SH);
        lin_addr   = lin_base_i + AW'(row) * stride_i
                   + (upper_half ? AW'(BEAT_B) : AW'(0));
        rd_addr_o  = mode_i.load ? tiled_addr : lin_addr;
        wr_addr_o  = mode_i.load ? lin_addr : tiled_addr;
    end
endmodule

// File: rtl/utile_seq.sv
module utile_seq
    import utile_pkg::*;
#(
    parameter int BEATS = TILE_BYTES / BEAT_BYTES,
    parameter int BW = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          legal_i,
    input  logic          rd_ready_i,
    input  logic          rsp_valid_i,
    input  logic          wr_ready_i,
    output logic          accept_o,
    output logic          rsp_take_o,
    output logic          rd_valid_o,
    output logic          wr_valid_o,
    output logic [BW-1:0] beat_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    mover_state_t  st;
    logic [BW-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            beat   <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    if (legal_i) begin
                        st   <= S_RD;
                        beat <= '0;
                    end else begin
                        err_o <= 1'b1;
                    end
                end
                S_RD:  if (rd_ready_i)  st <= S_RSP;
                S_RSP: if (rsp_valid_i) st <= S_WR;
                S_WR:  if (wr_ready_i) begin
                    if (beat == LAST) begin
                        st     <= S_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        beat <= beat + 1'b1;
                        st   <= S_RD;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign accept_o   = (st == S_IDLE) && start_i && legal_i;
    assign rsp_take_o = (st == S_RSP) && rsp_valid_i;
    assign rd_valid_o = (st == S_RD);
    assign wr_valid_o = (st == S_WR);
    assign busy_o     = (st != S_IDLE);
    assign beat_o     = beat;
endmodule

// File: rtl/utile_mover.sv
module utile_mover
    import utile_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = BEAT_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          to_linear_i,
    input  logic [3:0]    pix_bytes_i,
    input  logic [AW-1:0] tile_base_i,
    input  logic [AW-1:0] lin_base_i,
    input  logic [AW-1:0] lin_stride_i,
    output logic          rd_valid_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ready_i,
    input  logic          rsp_valid_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ready_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int BEATS = TILE_BYTES / (DW / 8);
    localparam int BW    = $clog2(BEATS);

    mover_mode_t   mode_q;
    logic [AW-1:0] tile_q, lin_q, stride_q;
    logic [DW-1:0] data_q;
    logic          accept, rsp_take;
    logic [BW-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            tile_q   <= '0;
            lin_q    <= '0;
            stride_q <= '0;
            data_q   <= '0;
        end else begin
            if (accept) begin
                mode_q.load <= to_linear_i;
                mode_q.wide <= pix_wide(pix_bytes_i);
                tile_q      <= tile_base_i;
                lin_q       <= lin_base_i;
                stride_q    <= lin_stride_i;
            end
            if (rsp_take)
                data_q <= rsp_data_i;
        end
    end

    utile_seq #(.BEATS(BEATS), .BW(BW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .legal_i    (pix_legal(pix_bytes_i)),
        .rd_ready_i (rd_ready_i),
        .rsp_valid_i(rsp_valid_i),
        .wr_ready_i (wr_ready_i),
        .accept_o   (accept),
        .rsp_take_o (rsp_take),
        .rd_valid_o (rd_valid_o),
        .wr_valid_o (wr_valid_o),
        .beat_o     (beat),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    utile_addr_gen #(.AW(AW), .BEAT_B(DW / 8), .BW(BW)) u_addr (
        .mode_i     (mode_q),
        .beat_i     (beat),
        .tile_base_i(tile_q),
        .lin_base_i (lin_q),
        .stride_i   (stride_q),
        .rd_addr_o  (rd_addr_o),
        .wr_addr_o  (wr_addr_o)
    );

    assign wr_data_o = data_q;
endmodule

// File: rtl/utile_mover_chk.sv
module utile_mover_chk #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          rd_valid_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ready_i,
    input logic          wr_valid_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o,
    input logic          wr_ready_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o
);
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

    // R10
    one_side_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid_o && wr_valid_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && $past(wr_valid_o && wr_ready_i));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o && $past(start_i) && !$past(busy_o));
endmodule

bind utile_mover utile_mover_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .rd_valid_o(rd_valid_o),
    .rd_addr_o (rd_addr_o),
    .rd_ready_i(rd_ready_i),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ready_i(wr_ready_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/utile_mover_test.sv
module utile_mover_test;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int MEM = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          to_linear_i = 1'b0;
    logic [3:0]    pix_bytes_i = 4'd1;
    logic [AW-1:0] tile_base_i = '0;
    logic [AW-1:0] lin_base_i = '0;
    logic [AW-1:0] lin_stride_i = '0;
    logic          rd_valid_o, wr_valid_o, busy_o, done_o, err_o;
    logic [AW-1:0] rd_addr_o, wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          rd_ready_i = 1'b0;
    logic          wr_ready_i = 1'b0;
    logic          rsp_valid_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    int cycles = 0;

    logic [7:0]    mem [MEM];
    logic [7:0]    orig[MEM];
    logic [7:0]    expv[MEM];
    logic          pend = 1'b0;
    logic [AW-1:0] paddr = '0;

    always #10 clk = ~clk;

    utile_mover #(.AW(AW), .DW(DW)) uut (.*);

    // memory model with random stalls
    always @(posedge clk) begin
        cycles      <= cycles + 1;
        rd_ready_i  <= ($urandom % 4) != 0;
        wr_ready_i  <= ($urandom % 3) != 0;
        rsp_valid_i <= 1'b0;
        if (pend && ($urandom % 2 == 0)) begin
            pend        <= 1'b0;
            rsp_valid_i <= 1'b1;
            for (int n = 0; n < 8; n++)
                rsp_data_i[8*n +: 8] <= mem[(paddr + AW'(n)) % MEM];
        end
        if (rd_valid_o && rd_ready_i) begin
            pend  <= 1'b1;
            paddr <= rd_addr_o;
            reads <= reads + 1;
        end
        if (wr_valid_o && wr_ready_i)
            for (int n = 0; n < 8; n++)
                mem[(wr_addr_o + AW'(n)) % MEM] <= wr_data_o[8*n +: 8];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic run(input bit load, input int pb, input int stride, input int seed,
                       input bit poke);
        int rl, mism, tb, lb;
        bit seen;
        rl = (pb == 1) ? 8 : 16;
        tb = 'h140;
        lb = 'h403;
        for (int i = 0; i < MEM; i++) begin
            mem[i]  = 8'(i * 7 + seed * 13 + (i >> 8));
            orig[i] = mem[i];
            expv[i] = mem[i];
        end
        for (int k = 0; k < 64 / rl; k++)
            for (int j = 0; j < rl; j++)
                if (load) expv[lb + k * stride + j] = orig[tb + k * rl + j];
                else      expv[tb + k * rl + j] = orig[lb + k * stride + j];
        @(negedge clk);
        to_linear_i  = load;
        pix_bytes_i  = 4'(pb);
        tile_base_i  = AW'(tb);
        lin_base_i   = AW'(lb);
        lin_stride_i = AW'(stride);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R7 busy after start", longint'(busy_o), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i     = 1'b1;
            tile_base_i = AW'('h200);
            to_linear_i = !load;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        check(seen, "R7 done reached", longint'(seen), 1);
        check(!busy_o, "R7 busy low with done", longint'(busy_o), 0);
        @(negedge clk);
        check(!done_o, "R7 done one cycle", longint'(done_o), 0);
        mism = 0;
        for (int i = 0; i < MEM; i++)
            if (mem[i] !== expv[i]) mism++;
        if (pb == 1)
            check(mism == 0, load ? "R2 R4 R5 R10 load 8-byte rows" : "R2 R4 R5 R10 store 8-byte rows",
                  mism, 0);
        else
            check(mism == 0, load ? "R3 R4 R5 R10 load 16-byte rows" : "R3 R4 R5 R10 store 16-byte rows",
                  mism, 0);
        if (poke) begin
            int rc;
            rc = reads;
            repeat (30) @(negedge clk);
            check(reads == rc && !busy_o, "R8 no second transfer", reads - rc, 0);
        end
    endtask

    task automatic bad(input int pb);
        int rc;
        @(negedge clk);
        pix_bytes_i = 4'(pb);
        start_i     = 1'b1;
        rc          = reads;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, "R6 err pulse", longint'(err_o), 1);
        check(busy_o == 1'b0, "R6 stays idle", longint'(busy_o), 0);
        @(negedge clk);
        check(err_o == 1'b0, "R6 err one cycle", longint'(err_o), 0);
        repeat (20) @(negedge clk);
        check(reads == rc && !busy_o, "R6 no request", reads - rc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check({busy_o, done_o, err_o, rd_valid_o, wr_valid_o} == 5'b0,
              "R1 reset outputs", longint'({busy_o, done_o, err_o, rd_valid_o, wr_valid_o}), 0);
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 4; p++) begin
                int pb, rl;
                pb = 1 << p;
                rl = (pb == 1) ? 8 : 16;
                run(d[0], pb, rl, d * 8 + p, 0);
                run(d[0], pb, rl + 3, d * 8 + p + 1, 0);
                run(d[0], pb, 37, d * 8 + p + 2, 0);
                run(d[0], pb, 100, d * 8 + p + 3, 0);
            end
        // R8 start while busy
        run(1'b1, 2, 37, 5, 1);
        run(1'b0, 1, 21, 6, 1);
        bad(3);
        bad(0);
        bad(5);
        bad(15);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule